// File: doc/BRIEF.md
# Nested Interrupt Acknowledge Tracker

This block sits between an interrupt arbiter and the processor. The processor takes an interrupt by reading an acknowledge register. The block answers with the ID the arbiter currently rates best, or with the spurious code 1023 when that ID cannot preempt the running one. When the acknowledge is valid, the new ID becomes the running interrupt. The block records which ID it displaced, tells the pending logic to clear the new ID, and tells the request logic to drop the line to the processor.

The processor retires an interrupt by writing its ID to an end-of-interrupt register. If that ID is the running one, the block falls back to the ID it had displaced. If it is not, the block walks the stored links from the running ID, one link per clock, and splices the completed ID out of the chain. A later return then skips it. While the walk runs, a busy flag holds off all register traffic. On completion, a level-sensitive source whose line is still high and which is still enabled is reported back as pending.

Choosing the best candidate is done outside this block. The block receives that choice together with the per-ID priority, trigger, enable and line state.

Top module: `nat_tracker`

## Requirements
- R1: After reset the running ID is 1023, the running priority is 0x100, the priority mask reads 0xF0 and the control enable reads 0.
- R2: A read of offset 0x0C returns the best ID when that ID is not 1023, is below NUM_IDS, and has a priority value strictly below the running priority. That same access does four things: it makes the ID the running ID with its priority as the running priority, it links the ID to the previously running ID, it pulses `pend_clr_v` with `pend_clr_id` equal to the ID, and it pulses `req_drop`.
- R3: If the condition of R2 fails, the acknowledge returns 1023 and changes no state and raises no strobe.
- R4: A write to offset 0x10 while the running ID is 1023 is ignored: no strobe is raised and nothing changes.
- R5: Completing the running ID (write data bits [9:0] at 0x10) makes its stored link the running ID. The running priority becomes that ID's current priority, or 0x100 when the link is 1023.
- R6: Completing an ID that is not running leaves the running ID and priority unchanged. It removes the completed ID from the chain, so that later returns go from its successor directly to its predecessor. An ID that is not in the chain changes nothing.
- R7: A completion pulses `pend_set_v` with `pend_set_id` equal to the written ID exactly when that ID is level-sensitive (`trig_edge` bit 0), enabled and its line is high. Outside those conditions there is no pulse.
- R8: An out-of-order completion keeps `reg_busy` high for one cycle per link visited: k cycles when the target sits k links below the running ID, and chain-depth cycles when the target is absent. A request presented while busy is not accepted.
- R9: Offset 0x00 holds the enable in bit 0. Offset 0x04 holds the 8-bit priority mask. Offset 0x08 reads 0 and ignores writes. Offset 0x14 reads the running priority, and offset 0x18 reads the best ID.
- R10: Read data appears with `reg_rvalid` in the cycle after the read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| reg_rvalid | output | 1 | Read data valid |
| reg_busy | output | 1 | Chain walk in progress; requests are not accepted |
| best_id | input | 10 | Best candidate ID from the arbiter, 1023 = none |
| prio_flat | input | NUM_IDS*PRIO_W | Priority of each ID, ID i at bits [i*PRIO_W +: PRIO_W] |
| trig_edge | input | NUM_IDS | 1 = edge-triggered, 0 = level-sensitive |
| irq_en | input | NUM_IDS | Per-ID enable |
| line_lvl | input | NUM_IDS | Per-ID input line level |
| run_id | output | 10 | Running ID, 1023 = idle |
| run_prio | output | PRIO_W+1 | Running priority, 0x100 = idle |
| pend_clr_v | output | 1 | Clear-pending strobe |
| pend_clr_id | output | 10 | ID to clear |
| pend_set_v | output | 1 | Set-pending strobe |
| pend_set_id | output | 10 | ID to set |
| req_drop | output | 1 | Drop the processor request line |
| cpu_en | output | 1 | Control enable bit |
| prio_mask | output | PRIO_W | Priority mask |

## Verification
The bench sweeps every ID through an acknowledge and completion pair, with all eight trigger, enable and line combinations, so that a re-pend raised for an edge source or a disabled source shows up as a stray strobe. It builds a five-deep chain and retires each inner member out of order. A walk that splices the wrong entry would return to the completed ID, and a walk that gives up early would leave a stale link behind. Both show up in the return sequence and in the busy cycle count. An acknowledge whose priority equals the running priority must come back spurious; a design that used a non-strict compare would nest it. A write issued during a walk must leave the mask untouched.

// File: rtl/nat_pkg.sv
package nat_pkg;

    localparam int ID_W = 10;
    typedef logic [ID_W-1:0] id_t;
    localparam id_t ID_NONE = id_t'(1023);

    // Register operations, one per decoded offset/direction pair.
    typedef enum logic [2:0] {
        OP_NONE,
        OP_CTRL,
        OP_MASK,
        OP_BPR,
        OP_ACK,
        OP_EOI,
        OP_RPR,
        OP_HPP
    } op_e;

    typedef enum logic {
        WK_IDLE,
        WK_STEP
    } walk_e;

    typedef struct packed {
        logic v;
        id_t  id;
    } idpulse_t;

    function automatic op_e decode_op(input logic [4:0] off, input logic we);
        op_e r;
        r = OP_NONE;
        if (off[1:0] == 2'b00) begin
            case (off[4:2])
                3'd0: r = OP_CTRL;
                3'd1: r = OP_MASK;
                3'd2: r = OP_BPR;
                3'd3: r = we ? OP_NONE : OP_ACK;
                3'd4: r = we ? OP_EOI : OP_NONE;
                3'd5: r = we ? OP_NONE : OP_RPR;
                3'd6: r = we ? OP_NONE : OP_HPP;
                default: r = OP_NONE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/nat_regdec.sv
module nat_regdec
    import nat_pkg::*;
(
    input  logic        req,
    input  logic        we,
    input  logic [4:0]  addr,
    input  logic [31:0] wdata,
    input  logic        busy,
    output logic        accept,
    output op_e         op,
    output logic        ack_go,
    output logic        eoi_go,
    output id_t         eoi_id
);
    always_comb begin
        accept = req && !busy;
        op     = accept ? decode_op(addr, we) : OP_NONE;
        ack_go = (op == OP_ACK);
        eoi_go = (op == OP_EOI);
        eoi_id = wdata[ID_W-1:0];
    end
endmodule

// File: rtl/nat_chain.sv
module nat_chain
    import nat_pkg::*;
#(
    parameter int NUM_IDS = 64,
    parameter int PRIO_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ack_go,
    input  logic                      eoi_go,
    input  id_t                       eoi_id,
    input  id_t                       best_id,
    input  logic [NUM_IDS*PRIO_W-1:0] prio_flat,
    input  logic [NUM_IDS-1:0]        trig_edge,
    input  logic [NUM_IDS-1:0]        irq_en,
    input  logic [NUM_IDS-1:0]        line_lvl,
    output id_t                       run_id,
    output logic [PRIO_W:0]           run_prio,
    output logic                      ack_ok,
    output logic                      busy,
    output idpulse_t                  pend_set,
    output idpulse_t                  pend_clr,
    output logic                      drop
);
    localparam int IX_W = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1;
    localparam id_t ID_LIMIT = id_t'(NUM_IDS);
    localparam logic [PRIO_W:0] RP_IDLE = {1'b1, {PRIO_W{1'b0}}};

    id_t   link_q [NUM_IDS];
    walk_e wk_q;
    id_t   cur_q;
    id_t   tgt_q;

    logic [IX_W-1:0] best_ix, run_ix, eoi_ix, cur_ix, tgt_ix, pop_ix;
    logic            best_in, eoi_in, tgt_in, pop_in;
    logic [PRIO_W:0] best_p, pop_p;
    id_t             pop_id, nxt_id;
    logic            repend;

    always_comb begin
        best_ix = best_id[IX_W-1:0];
        run_ix  = run_id[IX_W-1:0];
        eoi_ix  = eoi_id[IX_W-1:0];
        cur_ix  = cur_q[IX_W-1:0];
        tgt_ix  = tgt_q[IX_W-1:0];

        best_in = (best_id < ID_LIMIT);
        eoi_in  = (eoi_id < ID_LIMIT);
        tgt_in  = (tgt_q < ID_LIMIT);

        best_p  = best_in ? {1'b0, prio_flat[best_ix*PRIO_W +: PRIO_W]} : RP_IDLE;
        ack_ok  = (best_id != ID_NONE) && best_in && (best_p < run_prio);

        pop_id  = link_q[run_ix];
        pop_ix  = pop_id[IX_W-1:0];
        pop_in  = (pop_id < ID_LIMIT);
        pop_p   = pop_in ? {1'b0, prio_flat[pop_ix*PRIO_W +: PRIO_W]} : RP_IDLE;

        nxt_id  = link_q[cur_ix];
        repend  = eoi_in && !trig_edge[eoi_ix] && irq_en[eoi_ix] && line_lvl[eoi_ix];
        busy    = (wk_q == WK_STEP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_id   <= ID_NONE;
            run_prio <= RP_IDLE;
            wk_q     <= WK_IDLE;
            cur_q    <= ID_NONE;
            tgt_q    <= ID_NONE;
            pend_set <= '{v: 1'b0, id: ID_NONE};
            pend_clr <= '{v: 1'b0, id: ID_NONE};
            drop     <= 1'b0;
            for (int i = 0; i < NUM_IDS; i++) begin
                link_q[i] <= ID_NONE;
            end
        end else begin
            pend_set.v <= 1'b0;
            pend_clr.v <= 1'b0;
            drop       <= 1'b0;
            case (wk_q)
                WK_IDLE: begin
                    if (ack_go && ack_ok) begin
                        link_q[best_ix] <= run_id;
                        run_id          <= best_id;
                        run_prio        <= best_p;
                        pend_clr        <= '{v: 1'b1, id: best_id};
                        drop            <= 1'b1;
                    end else if (eoi_go && (run_id != ID_NONE)) begin
                        if (repend) begin
                            pend_set <= '{v: 1'b1, id: eoi_id};
                        end
                        if (eoi_id == run_id) begin
                            run_id   <= pop_id;
                            run_prio <= pop_p;
                        end else begin
                            wk_q  <= WK_STEP;
                            cur_q <= run_id;
                            tgt_q <= eoi_id;
                        end
                    end
                end
                WK_STEP: begin
                    if (nxt_id == ID_NONE) begin
                        wk_q <= WK_IDLE;
                    end else if (nxt_id == tgt_q) begin
                        link_q[cur_ix] <= tgt_in ? link_q[tgt_ix] : ID_NONE;
                        wk_q           <= WK_IDLE;
                    end else begin
                        cur_q <= nxt_id;
                    end
                end
                default: wk_q <= WK_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nat_tracker.sv
module nat_tracker
    import nat_pkg::*;
#(
    parameter int NUM_IDS = 64,
    parameter int PRIO_W  = 8,
    parameter logic [PRIO_W-1:0] MASK_INIT = 8'hF0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      reg_req,
    input  logic                      reg_we,
    input  logic [4:0]                reg_addr,
    input  logic [31:0]               reg_wdata,
    output logic [31:0]               reg_rdata,
    output logic                      reg_rvalid,
    output logic                      reg_busy,
    input  logic [9:0]                best_id,
    input  logic [NUM_IDS*PRIO_W-1:0] prio_flat,
    input  logic [NUM_IDS-1:0]        trig_edge,
    input  logic [NUM_IDS-1:0]        irq_en,
    input  logic [NUM_IDS-1:0]        line_lvl,
    output logic [9:0]                run_id,
    output logic [PRIO_W:0]           run_prio,
    output logic                      pend_clr_v,
    output logic [9:0]                pend_clr_id,
    output logic                      pend_set_v,
    output logic [9:0]                pend_set_id,
    output logic                      req_drop,
    output logic                      cpu_en,
    output logic [PRIO_W-1:0]         prio_mask
);
    logic     accept;
    op_e      op;
    logic     ack_go, eoi_go, ack_ok;
    id_t      eoi_id;
    idpulse_t set_p, clr_p;
    logic [31:0] rd_mux;
    logic        unused_wbits;

    assign unused_wbits = ^reg_wdata[31:ID_W];

    nat_regdec u_dec (
        .req    (reg_req),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .busy   (reg_busy),
        .accept (accept),
        .op     (op),
        .ack_go (ack_go),
        .eoi_go (eoi_go),
        .eoi_id (eoi_id)
    );

    nat_chain #(.NUM_IDS(NUM_IDS), .PRIO_W(PRIO_W)) u_chain (
        .clk       (clk),
        .rst       (rst),
        .ack_go    (ack_go),
        .eoi_go    (eoi_go),
        .eoi_id    (eoi_id),
        .best_id   (best_id),
        .prio_flat (prio_flat),
        .trig_edge (trig_edge),
        .irq_en    (irq_en),
        .line_lvl  (line_lvl),
        .run_id    (run_id),
        .run_prio  (run_prio),
        .ack_ok    (ack_ok),
        .busy      (reg_busy),
        .pend_set  (set_p),
        .pend_clr  (clr_p),
        .drop      (req_drop)
    );

    assign pend_set_v  = set_p.v;
    assign pend_set_id = set_p.id;
    assign pend_clr_v  = clr_p.v;
    assign pend_clr_id = clr_p.id;

    always_comb begin
        case (op)
            OP_CTRL: rd_mux = {31'd0, cpu_en};
            OP_MASK: rd_mux = 32'(prio_mask);
            OP_ACK:  rd_mux = 32'(ack_ok ? best_id : ID_NONE);
            OP_RPR:  rd_mux = 32'(run_prio);
            OP_HPP:  rd_mux = 32'(best_id);
            default: rd_mux = 32'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_en     <= 1'b0;
            prio_mask  <= MASK_INIT;
            reg_rdata  <= 32'd0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= accept && !reg_we;
            if (accept && !reg_we) begin
                reg_rdata <= rd_mux;
            end
            if (accept && reg_we) begin
                if (op == OP_CTRL) cpu_en    <= reg_wdata[0];
                if (op == OP_MASK) prio_mask <= reg_wdata[PRIO_W-1:0];
            end
        end
    end
endmodule

// File: rtl/nat_tracker_chk.sv
module nat_tracker_chk #(
    parameter int PRIO_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_req,
    input logic              reg_we,
    input logic [4:0]        reg_addr,
    input logic              reg_busy,
    input logic [9:0]        run_id,
    input logic [PRIO_W:0]   run_prio,
    input logic              pend_clr_v,
    input logic [9:0]        pend_clr_id,
    input logic              pend_set_v,
    input logic              req_drop,
    input logic              cpu_en,
    input logic [PRIO_W-1:0] prio_mask
);
    localparam logic [PRIO_W:0] IDLE_P = {1'b1, {PRIO_W{1'b0}}};

    p_idle_prio_r5: assert property (@(posedge clk) disable iff (rst)
        (run_id == 10'd1023) |-> (run_prio == IDLE_P));

    p_active_prio_r2: assert property (@(posedge clk) disable iff (rst)
        (run_id != 10'd1023) |-> (run_prio < IDLE_P));

    p_ack_pair_r2: assert property (@(posedge clk) disable iff (rst)
        req_drop |-> (pend_clr_v && (pend_clr_id == run_id)));

    p_nest_lower_r2: assert property (@(posedge clk) disable iff (rst)
        req_drop |-> (run_prio < $past(run_prio)));

    p_busy_block_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_busy && reg_req && reg_we) |=> ($stable(prio_mask) && $stable(cpu_en)));

    p_eoi_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_req && reg_we && !reg_busy && (reg_addr == 5'h10) && (run_id == 10'd1023))
        |=> (!pend_set_v && (run_id == 10'd1023)));
endmodule

bind nat_tracker nat_tracker_chk #(.PRIO_W(PRIO_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .reg_req     (reg_req),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_busy    (reg_busy),
    .run_id      (run_id),
    .run_prio    (run_prio),
    .pend_clr_v  (pend_clr_v),
    .pend_clr_id (pend_clr_id),
    .pend_set_v  (pend_set_v),
    .req_drop    (req_drop),
    .cpu_en      (cpu_en),
    .prio_mask   (prio_mask)
);

// File: tb/nat_tracker_tb_top.sv
module nat_tracker_tb_top;
    localparam int N  = 64;
    localparam int PW = 8;
    localparam logic [9:0] NONE = 10'd1023;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        reg_req = 1'b0, reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid, reg_busy;
    logic [9:0]  best_id = NONE;
    logic [PW-1:0] prio_arr [N];
    logic [N*PW-1:0] prio_flat;
    logic [N-1:0] trig_edge = '1, irq_en = '0, line_lvl = '0;
    logic [9:0]  run_id, pend_clr_id, pend_set_id;
    logic [PW:0] run_prio;
    logic        pend_clr_v, pend_set_v, req_drop, cpu_en;
    logic [PW-1:0] prio_mask;

    always_comb begin
        for (int i = 0; i < N; i++) prio_flat[i*PW +: PW] = prio_arr[i];
    end

    nat_tracker #(.NUM_IDS(N), .PRIO_W(PW)) dut_i (.*);

    int n_chk = 0, n_fail = 0;
    logic s_drop, s_clr_v, s_set_v;
    logic [9:0] s_clr_id, s_set_id;
    logic [31:0] rd;
    logic [9:0] chain [5];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        while (reg_busy) @(negedge clk);
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
        wait_idle();
        reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_req = 1'b0;
        chk("R10 rvalid", 32'(reg_rvalid), 32'd1);
        d = reg_rdata;
        s_drop = req_drop; s_clr_v = pend_clr_v; s_clr_id = pend_clr_id;
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
        wait_idle();
        reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_req = 1'b0;
        s_set_v = pend_set_v; s_set_id = pend_set_id;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (reg_busy) begin n++; @(negedge clk); end
    endtask

    task automatic build_chain();
        for (int k = 0; k < 5; k++) begin
            best_id = chain[k];
            reg_read(5'h0C, rd);
            chk("R2 nested ack", rd, 32'(chain[k]));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int nb;
        for (int i = 0; i < N; i++) prio_arr[i] = PW'((i * 37 + 11) & 8'hFF);
        for (int k = 0; k < 5; k++) chain[k] = 10'(8 + 3 * k);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 run_id", 32'(run_id), 32'(NONE));
        chk("R1 run_prio", 32'(run_prio), 32'h100);
        reg_read(5'h04, rd); chk("R1 mask", rd, 32'hF0);
        reg_read(5'h00, rd); chk("R1 ctrl", rd, 32'h0);
        reg_read(5'h14, rd); chk("R1 rpr", rd, 32'h100);

        // R9 registers
        reg_write(5'h00, 32'hFFFF_FFFF); reg_read(5'h00, rd); chk("R9 ctrl", rd, 32'h1);
        chk("R9 cpu_en", 32'(cpu_en), 32'h1);
        reg_write(5'h04, 32'h1234_56AB); reg_read(5'h04, rd); chk("R9 mask", rd, 32'hAB);
        reg_write(5'h08, 32'hFFFF_FFFF); reg_read(5'h08, rd); chk("R9 bpr", rd, 32'h0);
        reg_read(5'h04, rd); chk("R9 mask after bpr write", rd, 32'hAB);
        best_id = 10'd37; reg_read(5'h18, rd); chk("R9 hpp", rd, 32'd37);

        // R4 completion while idle
        trig_edge[5] = 1'b0; irq_en[5] = 1'b1; line_lvl[5] = 1'b1;
        reg_write(5'h10, 32'd5);
        chk("R4 no pend_set", 32'(s_set_v), 32'd0);
        chk("R4 run_id", 32'(run_id), 32'(NONE));

        // R3 spurious: no candidate
        best_id = NONE; reg_read(5'h0C, rd);
        chk("R3 none", rd, 32'(NONE));
        chk("R3 no drop", 32'(s_drop), 32'd0);

        // Sweep every ID: acknowledge, then complete (R2, R5, R7)
        for (int i = 0; i < N; i++) begin
            trig_edge[i] = i[0]; irq_en[i] = i[1]; line_lvl[i] = i[2];
            best_id = 10'(i);
            reg_read(5'h0C, rd);
            chk("R2 ack id", rd, 32'(i));
            chk("R2 drop", 32'(s_drop), 32'd1);
            chk("R2 clr", {s_clr_v, 21'd0, s_clr_id}, {1'b1, 21'd0, 10'(i)});
            chk("R2 run_id", 32'(run_id), 32'(i));
            chk("R2 run_prio", 32'(run_prio), 32'(prio_arr[i]));
            reg_write(5'h10, 32'hFFFF_FC00 | 32'(i));
            chk("R7 repend", 32'(s_set_v), 32'(!i[0] && i[1] && i[2]));
            if (s_set_v) chk("R7 repend id", 32'(s_set_id), 32'(i));
            chk("R5 idle id", 32'(run_id), 32'(NONE));
            chk("R5 idle prio", 32'(run_prio), 32'h100);
        end
        trig_edge = '1;

        // Chain priorities: strictly decreasing values
        for (int k = 0; k < 5; k++) prio_arr[chain[k]] = PW'(8'hA0 - 8'h20 * k);
        prio_arr[50] = 8'h20;
        prio_arr[51] = 8'h1F;

        // R3 equal priority is spurious; R2 strictly lower nests
        build_chain();
        best_id = 10'd50; reg_read(5'h0C, rd);
        chk("R3 equal prio", rd, 32'(NONE));
        chk("R3 run unchanged", 32'(run_id), 32'(chain[4]));
        best_id = 10'd51; reg_read(5'h0C, rd);
        chk("R2 lower prio nests", rd, 32'd51);
        reg_write(5'h10, 32'd51);
        chk("R5 back to chain top", 32'(run_id), 32'(chain[4]));
        chk("R5 prio restored", 32'(run_prio), 32'h20);

        // R8/R6 absent target walks whole chain; write during busy blocked
        reg_write(5'h10, 32'd50);
        nb = 0;
        if (reg_busy) begin
            nb = 1;
            reg_req = 1'b1; reg_we = 1'b1; reg_addr = 5'h04; reg_wdata = 32'h11;
            @(negedge clk);
            reg_req = 1'b0;
            while (reg_busy) begin nb++; @(negedge clk); end
        end
        chk("R8 absent walk cycles", 32'(nb), 32'd5);
        reg_read(5'h04, rd); chk("R8 write during busy dropped", rd, 32'hAB);
        chk("R6 absent run_id", 32'(run_id), 32'(chain[4]));
        for (int k = 4; k >= 0; k--) begin
            reg_write(5'h10, 32'(chain[k]));
            chk("R5 pop", 32'(run_id), (k == 0) ? 32'(NONE) : 32'(chain[k-1]));
        end

        // R6/R8 out-of-order completion at each depth
        for (int p = 1; p <= 4; p++) begin
            build_chain();
            reg_write(5'h10, 32'(chain[4-p]));
            count_busy(nb);
            chk("R8 walk cycles", 32'(nb), 32'(p));
            chk("R6 run_id kept", 32'(run_id), 32'(chain[4]));
            chk("R6 run_prio kept", 32'(run_prio), 32'h20);
            for (int k = 4; k >= 0; k--) begin
                if (k != 4 - p) begin
                    int nx;
                    nx = k - 1;
                    if (nx == 4 - p) nx--;
                    reg_write(5'h10, 32'(chain[k]));
                    chk("R6 return order", 32'(run_id), (nx < 0) ? 32'(NONE) : 32'(chain[nx]));
                    chk("R6 return prio", 32'(run_prio),
                        (nx < 0) ? 32'h100 : 32'(prio_arr[chain[nx]]));
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule